// File: doc/BRIEF.md
# Floating-Point State-Enable Gate

This block stores the state-enable register 0 for three privilege levels: machine, hypervisor and supervisor. On a 32-bit hart, the machine and hypervisor registers also have an upper-half alias. A CSR write port updates these registers through a legal-bit mask, and a combinational read port returns the effective value of each one. A register's effective value is its stored value ANDed with the effective values of the levels above it.

The second function is an access check. For each floating-point access request it returns one of three verdicts one cycle later: allow, illegal-instruction trap or virtual-instruction trap. The verdict depends on the requester's privilege and virtualization state and on the FP-CSR enable bit at each level. Requests from the debugger skip the check. So do requests made while FP state is natively enabled. The FP-CSR enable bit can be written only on a hart built without hardware floating-point registers.

Top module: `fpstate_gate`

## Requirements
- R1: After reset, every stored register reads as zero and `rsp_valid` is low.
- R2: Only three bits of any register can be written: bit 63 (top enable), bit 62 (environment-config enable) and bit 1 (FP-CSR enable). Bit 1 is writable only when `HAS_F` is 0. All other bits always read zero.
- R3: When `HAS_F` is 1, bit 1 stays zero after any write, and bits 63 and 62 remain writable.
- R4: `wr_sel`/`rd_sel` codes: 0 selects machine low, 1 machine high, 2 hypervisor low, 3 hypervisor high, 4 supervisor, and 5 to 7 select nothing (reads return zero). With `XLEN` 32, a low code covers bits 31:0 and a high code covers bits 63:32. The supervisor register is reachable only through its low half.
- R5: Hypervisor reads return hypervisor AND machine. Supervisor reads return supervisor AND hypervisor AND machine. The stored values are kept when a higher level masks them.
- R6: A request with `req_priv` = 3 (machine) always gives verdict 0 (allow).
- R7: A request with `req_debug` high gives verdict 0 at any privilege.
- R8: A request with `req_fp_native` high gives verdict 0 at any privilege.
- R9: For an unbypassed non-machine request, a clear machine FP-CSR bit gives verdict 1 (illegal), whether or not the requester is virtualized.
- R10: If the machine bit is set, the requester is virtualized and the hypervisor bit is clear, the verdict is 2 (virtual).
- R11: For a user-mode request (`req_priv` = 0) that passes the levels above, a clear supervisor bit gives verdict 2 if virtualized and 1 if not. A supervisor-mode request (`req_priv` = 1, or the unused code 2) ignores the supervisor bit.
- R12: `rsp_valid` is `req_valid` delayed by one cycle, and `rsp_verdict` then holds the verdict for the state sampled at the request edge. Verdict code 3 never appears.
- R13: With `XLEN` 64, the high-half codes 1 and 3 have no effect on writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CSR write strobe |
| wr_sel | input | 3 | Write target code (R4) |
| wr_data | input | XLEN | Write data |
| rd_sel | input | 3 | Read target code (R4) |
| rd_data | output | XLEN | Effective value of the selected register |
| req_valid | input | 1 | FP access request strobe |
| req_priv | input | 2 | Requester privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Requester runs virtualized |
| req_fp_native | input | 1 | FP state natively enabled (check skipped) |
| req_debug | input | 1 | Access comes from the debugger (check skipped) |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_verdict | output | 2 | 0 allow, 1 illegal instruction, 2 virtual instruction |

## Verification
The bench builds two copies of the block. The first uses `XLEN` 32 with `HAS_F` 0. Because the FP-CSR bit is writable there, every branch of the three-level decision can be reached, along with the upper-half aliases and the masking of effective reads. The second uses `XLEN` 64 with `HAS_F` 1, which exposes the read-only FP-CSR bit and the inert high-half codes of a full-width hart.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int TOP_BIT  = 63;
  localparam int ENV_BIT  = 62;
  localparam int FCSR_BIT = 1;
  localparam int NUM_LVL  = 3;

  typedef enum logic [1:0] {
    V_ALLOW   = 2'd0,
    V_ILLEGAL = 2'd1,
    V_VIRT    = 2'd2
  } verdict_e;

  typedef struct packed {
    logic       known;
    logic       hi;
    logic [1:0] lvl;
  } sel_t;

  // Bits that software may change in any state-enable register 0.
  function automatic logic [63:0] legal_mask(input logic has_f);
    logic [63:0] m;
    m           = '0;
    m[TOP_BIT]  = 1'b1;
    m[ENV_BIT]  = 1'b1;
    m[FCSR_BIT] = !has_f;
    return m;
  endfunction

  // Map a select code to a level and a half.
  function automatic sel_t decode_sel(input logic [2:0] code);
    sel_t s;
    s = '{known: 1'b1, hi: 1'b0, lvl: 2'd0};
    case (code)
      3'd0: s.lvl = 2'd0;
      3'd1: begin s.lvl = 2'd0; s.hi = 1'b1; end
      3'd2: s.lvl = 2'd1;
      3'd3: begin s.lvl = 2'd1; s.hi = 1'b1; end
      3'd4: s.lvl = 2'd2;
      default: s.known = 1'b0;
    endcase
    return s;
  endfunction

  // Access decision for a floating-point request.
  function automatic verdict_e judge(input logic [1:0] priv, input logic virt,
                                     input logic native, input logic debug,
                                     input logic m_on, input logic h_on,
                                     input logic s_on);
    if (debug || native || priv == 2'd3) return V_ALLOW;
    if (!m_on)                           return V_ILLEGAL;
    if (virt && !h_on)                   return V_VIRT;
    if (priv == 2'd0 && !s_on)           return virt ? V_VIRT : V_ILLEGAL;
    return V_ALLOW;
  endfunction

endpackage

// File: rtl/fsg_bank.sv
module fsg_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [63:0] wmask,
  input  logic [63:0] wdata,
  output logic [63:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= (q & ~wmask) | (wdata & wmask);
  end
endmodule

// File: rtl/fsg_decide.sv
module fsg_decide
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_priv,
  input  logic       req_virt,
  input  logic       req_fp_native,
  input  logic       req_debug,
  input  logic       m_on,
  input  logic       h_on,
  input  logic       s_on,
  output logic       rsp_valid,
  output verdict_e   rsp_verdict
);
  verdict_e next_verdict;

  always_comb
    next_verdict = judge(req_priv, req_virt, req_fp_native, req_debug, m_on, h_on, s_on);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_verdict <= V_ALLOW;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_verdict <= next_verdict;
    end
  end
endmodule

// File: rtl/fpstate_gate.sv
module fpstate_gate
  import fsg_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int HAS_F = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [2:0]      rd_sel,
  output logic [XLEN-1:0] rd_data,
  input  logic            req_valid,
  input  logic [1:0]      req_priv,
  input  logic            req_virt,
  input  logic            req_fp_native,
  input  logic            req_debug,
  output logic            rsp_valid,
  output logic [1:0]      rsp_verdict
);
  localparam logic [63:0] WMASK    = legal_mask(HAS_F != 0);
  localparam logic [63:0] LOW_HALF = 64'h0000_0000_FFFF_FFFF;

  sel_t        wsel, rsel;
  logic [63:0] wide_data, lane_mask;
  logic [63:0] lvl_q   [NUM_LVL];
  logic [63:0] lvl_eff [NUM_LVL];
  logic [63:0] picked;

  // Named views for the checker.
  logic [63:0] m_q, h_q, s_q;
  logic        fcsr_m, fcsr_h, fcsr_s;
  verdict_e    verdict_q;

  always_comb wsel = decode_sel(wr_sel);
  always_comb rsel = decode_sel(rd_sel);

  generate
    if (XLEN == 32) begin : g_half
      always_comb begin
        wide_data = wsel.hi ? {wr_data, 32'h0} : {32'h0, wr_data};
        lane_mask = wsel.hi ? ~LOW_HALF : LOW_HALF;
      end
      always_comb rd_data = !rsel.known ? '0 : (rsel.hi ? picked[63:32] : picked[31:0]);
    end else begin : g_full
      always_comb begin
        wide_data = wr_data;
        lane_mask = wsel.hi ? '0 : '1;
      end
      always_comb rd_data = (!rsel.known || rsel.hi) ? '0 : picked;
    end
  endgenerate

  generate
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      fsg_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && wsel.known && wsel.lvl == 2'(g)),
        .wmask (WMASK & lane_mask),
        .wdata (wide_data),
        .q     (lvl_q[g])
      );
      if (g == 0) begin : g_root
        always_comb lvl_eff[g] = lvl_q[g];
      end else begin : g_chain
        always_comb lvl_eff[g] = lvl_q[g] & lvl_eff[g-1];
      end
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (rsel.lvl == 2'(i)) picked = lvl_eff[i];
  end

  always_comb begin
    m_q    = lvl_q[0];
    h_q    = lvl_q[1];
    s_q    = lvl_q[2];
    fcsr_m = m_q[FCSR_BIT];
    fcsr_h = h_q[FCSR_BIT];
    fcsr_s = s_q[FCSR_BIT];
  end

  fsg_decide u_decide (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_priv      (req_priv),
    .req_virt      (req_virt),
    .req_fp_native (req_fp_native),
    .req_debug     (req_debug),
    .m_on          (fcsr_m),
    .h_on          (fcsr_h),
    .s_on          (fcsr_s),
    .rsp_valid     (rsp_valid),
    .rsp_verdict   (verdict_q)
  );

  assign rsp_verdict = verdict_q;

endmodule

module fsg_checker
  import fsg_pkg::*;
#(
  parameter int HAS_F = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_priv,
  input logic        req_fp_native,
  input logic        req_debug,
  input logic        rsp_valid,
  input logic [1:0]  rsp_verdict,
  input logic [63:0] m_q,
  input logic [63:0] h_q,
  input logic [63:0] s_q,
  input logic        fcsr_m
);
  localparam logic [63:0] WMASK = legal_mask(HAS_F != 0);

  AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_q | h_q | s_q) & ~WMASK) == 64'h0);  // R2
  AST_MACHINE_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd3) |=> (rsp_verdict == 2'd0));  // R6
  AST_DEBUG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_debug) |=> (rsp_verdict == 2'd0));  // R7
  AST_NATIVE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fp_native) |=> (rsp_verdict == 2'd0));  // R8
  AST_MCLEAR_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != 2'd3 && !req_debug && !req_fp_native && !fcsr_m)
      |=> (rsp_verdict == 2'd1));  // R9
  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R12
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R12
  AST_VERDICT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_verdict != 2'd3);  // R12
endmodule

bind fpstate_gate fsg_checker #(.HAS_F(HAS_F)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_priv      (req_priv),
  .req_fp_native (req_fp_native),
  .req_debug     (req_debug),
  .rsp_valid     (rsp_valid),
  .rsp_verdict   (rsp_verdict),
  .m_q           (m_q),
  .h_q           (h_q),
  .s_q           (s_q),
  .fcsr_m        (fcsr_m)
);

// File: tb/fpstate_gate_test.sv
module fpstate_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] ALLOW = 2'd0, ILL = 2'd1, VIRT = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // 32-bit hart without hardware FP registers
  logic        a_wr_en = 0, a_req_valid = 0, a_req_virt = 0, a_req_native = 0, a_req_debug = 0;
  logic [2:0]  a_wr_sel = 0, a_rd_sel = 0;
  logic [31:0] a_wr_data = 0, a_rd_data;
  logic [1:0]  a_req_priv = 0, a_rsp_verdict;
  logic        a_rsp_valid;

  // 64-bit hart with hardware FP registers
  logic        b_wr_en = 0;
  logic [2:0]  b_wr_sel = 0, b_rd_sel = 0;
  logic [63:0] b_wr_data = 0, b_rd_data;
  logic [1:0]  b_rsp_verdict;
  logic        b_rsp_valid;

  fpstate_gate #(.XLEN(32), .HAS_F(0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_sel(a_wr_sel), .wr_data(a_wr_data),
    .rd_sel(a_rd_sel), .rd_data(a_rd_data), .req_valid(a_req_valid), .req_priv(a_req_priv),
    .req_virt(a_req_virt), .req_fp_native(a_req_native), .req_debug(a_req_debug),
    .rsp_valid(a_rsp_valid), .rsp_verdict(a_rsp_verdict));

  fpstate_gate #(.XLEN(64), .HAS_F(1)) uut_f64 (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_sel(b_wr_sel), .wr_data(b_wr_data),
    .rd_sel(b_rd_sel), .rd_data(b_rd_data), .req_valid(1'b0), .req_priv(2'd0),
    .req_virt(1'b0), .req_fp_native(1'b0), .req_debug(1'b0),
    .rsp_valid(b_rsp_valid), .rsp_verdict(b_rsp_verdict));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    a_wr_en = 1; a_wr_sel = sel; a_wr_data = data;
    @(negedge clk);
    a_wr_en = 0;
  endtask

  task automatic rd_a(input logic [2:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    a_rd_sel = sel;
    #1;
    check(req, 64'(a_rd_data), 64'(exp));
  endtask

  task automatic wr_b(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    b_wr_en = 1; b_wr_sel = sel; b_wr_data = data;
    @(negedge clk);
    b_wr_en = 0;
  endtask

  task automatic rd_b(input logic [2:0] sel, input logic [63:0] exp, input string req);
    @(negedge clk);
    b_rd_sel = sel;
    #1;
    check(req, b_rd_data, exp);
  endtask

  task automatic ask_a(input logic [1:0] priv, input logic virt, input logic native,
                       input logic debug, input logic [1:0] exp, input string req);
    @(negedge clk);
    a_req_valid = 1; a_req_priv = priv; a_req_virt = virt;
    a_req_native = native; a_req_debug = debug;
    @(posedge clk);
    #1;
    check(req, {61'h0, a_rsp_valid, a_rsp_verdict}, {61'h0, 1'b1, exp});
    @(negedge clk);
    a_req_valid = 0; a_req_native = 0; a_req_debug = 0; a_req_virt = 0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 5; s++) rd_a(3'(s), 32'h0, "R1 reset value");
    rd_b(3'd0, 64'h0, "R1 reset value wide");
    check("R1 rsp_valid after reset", {63'h0, a_rsp_valid}, 64'h0);
  endtask

  task automatic t_mask_machine;
    wr_a(3'd0, 32'hFFFF_FFFF);
    rd_a(3'd0, 32'h0000_0002, "R2 machine low mask");
    wr_a(3'd1, 32'hFFFF_FFFF);
    rd_a(3'd1, 32'hC000_0000, "R2 machine high mask");
    rd_a(3'd5, 32'h0, "R4 unused select reads zero");
  endtask

  task automatic t_levels;
    wr_a(3'd2, 32'hFFFF_FFFF);
    wr_a(3'd3, 32'hFFFF_FFFF);
    wr_a(3'd4, 32'hFFFF_FFFF);
    rd_a(3'd2, 32'h0000_0002, "R4 hypervisor low");
    rd_a(3'd3, 32'hC000_0000, "R4 hypervisor high");
    rd_a(3'd4, 32'h0000_0002, "R4 supervisor");
  endtask

  task automatic t_machine_clear;
    wr_a(3'd0, 32'h0);
    rd_a(3'd2, 32'h0, "R5 hypervisor masked by machine");
    rd_a(3'd4, 32'h0, "R5 supervisor masked by machine");
    rd_a(3'd3, 32'hC000_0000, "R5 high half unaffected");
    ask_a(PS, 0, 0, 0, ILL,   "R9 supervisor with machine clear");
    ask_a(PU, 1, 0, 0, ILL,   "R9 virtual user with machine clear");
    ask_a(PM, 0, 0, 0, ALLOW, "R6 machine always allowed");
    ask_a(PS, 1, 0, 1, ALLOW, "R7 debugger bypass");
    ask_a(PU, 0, 1, 0, ALLOW, "R8 native FP bypass");
    wr_a(3'd0, 32'hFFFF_FFFF);
    rd_a(3'd2, 32'h0000_0002, "R5 stored value kept");
  endtask

  task automatic t_hyp_gate;
    ask_a(PU, 1, 0, 0, ALLOW, "R10 all enabled virtual user");
    wr_a(3'd2, 32'h0);
    ask_a(PS, 1, 0, 0, VIRT,  "R10 virtual supervisor with hypervisor clear");
    ask_a(PU, 1, 0, 0, VIRT,  "R10 virtual user with hypervisor clear");
    ask_a(PS, 0, 0, 0, ALLOW, "R10 non-virtual ignores hypervisor bit");
    wr_a(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_user_gate;
    wr_a(3'd4, 32'h0);
    ask_a(PU, 1, 0, 0, VIRT,  "R11 virtual user with supervisor clear");
    ask_a(PU, 0, 0, 0, ILL,   "R11 user with supervisor clear");
    ask_a(PS, 0, 0, 0, ALLOW, "R11 supervisor ignores supervisor bit");
    ask_a(2'd2, 1, 0, 0, ALLOW, "R11 unused privilege code acts as supervisor");
  endtask

  task automatic t_handshake;
    ask_a(PU, 0, 0, 0, ILL, "R12 response one cycle later");
    @(posedge clk);
    #1;
    check("R12 rsp_valid drops", {63'h0, a_rsp_valid}, 64'h0);
  endtask

  task automatic t_wide_with_f;
    wr_b(3'd0, '1);
    rd_b(3'd0, 64'hC000_0000_0000_0000, "R3 FP-CSR bit read-only with F");
    wr_b(3'd2, '1);
    rd_b(3'd2, 64'hC000_0000_0000_0000, "R3 hypervisor with F");
    wr_b(3'd1, 64'h0);
    rd_b(3'd0, 64'hC000_0000_0000_0000, "R13 high code write ignored");
    rd_b(3'd1, 64'h0, "R13 high code reads zero");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mask_machine();
    t_levels();
    t_machine_clear();
    t_hyp_gate();
    t_user_gate();
    t_handshake();
    t_wide_with_f();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule